// File: doc/BRIEF.md
# Tuner Synthesizer Control-Register Slave

This block holds the control registers of a television tuner frequency synthesizer and exposes them on a two-wire I2C bus as a slave device. The master writes the 15-bit divider ratio, a control byte and a band byte. It reads back a single status byte that reports a power-up flag, the loop-lock flag and a 3-bit code for the tuning voltage. The analog loop, oscillator and converter sit outside the block. Lock and the converter code enter as inputs that are synchronous to `clk_i`.

Both bus lines are sampled by the system clock, which must run at least twenty times faster than SCL. The block drives SDA only through an open-drain enable. Each data byte in a write is sorted by its most significant bit. A clear MSB opens a divider pair and a set MSB opens a control/band pair. Staged values reach the synthesizer outputs only at the STOP condition, so the divider never shows a half-written value.

Top module: `tuner_syn_regs`

## Requirements
- R1: After reset the outputs are `div_o`=0, `cp_o`=0, `test_o`=0, `os_o`=0 and `band_o`=0, and `sda_oe_o` is 0.
- R2: The slave pulls SDA low in the ninth bit (ACK) only for address byte `{5'b11000, as_i[1:0], rw}`, which is 0xC0/0xC1 when both select pins are low. It ACKs every data byte of a write it has accepted. For any other address it stays released, and the rest of that transfer has no effect on any output.
- R3: In a write, a byte with bit 7 = 0 is divider byte 1 and supplies N[14:8] from its bits 6:0. The next byte is divider byte 2 and supplies N[7:0]. `div_o` = N.
- R4: In a write, a byte with bit 7 = 1 is the control byte: bit 6 = charge-pump select (`cp_o`, 1 = high current), bits 5:3 = test code (`test_o`, 000 = normal), bit 0 = tuning-amplifier off (`os_o`). The next byte is the band byte.
- R5: Outputs change only in response to a STOP condition. While a write is in progress, the previously committed values stay on all outputs.
- R6: A divider byte 1 that is not followed by divider byte 2 before STOP leaves `div_o` unchanged. A START resets the byte sorting, so the next byte is classified afresh.
- R7: The status byte is `{por, lock_i, 3'b000, adc_i[2:0]}`, MSB first.
- R8: The power-up flag is 1 after reset. It clears at the STOP that ends a read in which at least one status byte was sent in full, and it only becomes 1 again on reset.
- R9: While the master ACKs, the read goes on returning the status byte. Each repeat is formed anew from the current inputs, and the flag is unchanged within the transfer.
- R10: The band byte is copied unchanged to `band_o` (0x01 low, 0x02 mid, 0x08 high band).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| as_i | input | 2 | Address select pins, address bits 2:1 |
| lock_i | input | 1 | Loop lock indication |
| adc_i | input | 3 | Tuning-voltage converter code |
| div_o | output | 15 | Divider ratio N |
| cp_o | output | 1 | Charge-pump current select |
| test_o | output | 3 | Test-mode code |
| os_o | output | 1 | Tuning amplifier disable |
| band_o | output | 8 | Band-switch byte |

## Verification
The hardest state to reach is a divider pair left open at STOP, which must not reach `div_o`. The bench sends a lone byte with bit 7 clear and then closes the transfer, and it also restarts sorting with an address-mismatched transfer and with a change of the select pins. Clearing the power-up flag requires a complete status byte followed by the master's acknowledge slot and a STOP. The bench therefore reads once with NACK and once with several ACKed repeats, and it reapplies reset to show that the flag comes back.

// File: rtl/tsyn_pkg.sv
package tsyn_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_BYTE, ST_WR_ACK, ST_RD_BYTE, ST_RD_ACK
  } bus_state_e;

  typedef enum logic [1:0] {
    EXP_ANY, EXP_DIV_LO, EXP_BAND
  } byte_kind_e;

  localparam int unsigned CTRL_MARK_BIT = 7;
  localparam int unsigned CTRL_CP_BIT   = 6;
  localparam int unsigned CTRL_T_LSB    = 3;
  localparam int unsigned CTRL_OS_BIT   = 0;
endpackage

// File: rtl/tsyn_line_mon.sv
module tsyn_line_mon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned NL = 2;
  logic [NL-1:0] raw;
  logic [NL-1:0] synced;
  logic [NL-1:0] prev;

  assign raw = {scl_i, sda_i};

  for (genvar l = 0; l < NL; l++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[SYNC_STAGES-2:0], raw[l]};
    end
    assign synced[l] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= '1;
    else         prev <= synced;
  end

  assign scl_o      = synced[1];
  assign sda_o      = synced[0];
  assign scl_rise_o = synced[1] & ~prev[1];
  assign scl_fall_o = ~synced[1] & prev[1];
  // data edges while the clock stays high
  assign start_o    = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_o     = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/tsyn_bit_engine.sv
module tsyn_bit_engine
  import tsyn_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_i,
  input  logic [6:0]        dev_addr_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_done_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  bus_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] tx_q;
  logic              acked_q;
  logic              oe_q;
  logic              addr_hit;

  assign addr_hit  = (sh_q[BYTE_W-1:1] == dev_addr_i);
  assign sda_oe_o  = oe_q;
  assign wr_data_o = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      acked_q   <= 1'b0;
      oe_q      <= 1'b0;
      wr_stb_o  <= 1'b0;
      rd_done_o <= 1'b0;
    end else begin
      wr_stb_o  <= 1'b0;
      rd_done_o <= 1'b0;
      if (stop_i) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else if (start_i) begin
        st_q  <= ST_ADDR;
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: ;
          ST_ADDR, ST_WR_BYTE: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == CNT_W'(BYTE_W)) begin
              if (st_q == ST_ADDR) begin
                if (addr_hit) begin
                  st_q <= ST_ADDR_ACK;
                  oe_q <= 1'b1;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                st_q     <= ST_WR_ACK;
                oe_q     <= 1'b1;
                wr_stb_o <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (sh_q[0]) begin
                st_q <= ST_RD_BYTE;
                tx_q <= status_i;
                oe_q <= ~status_i[BYTE_W-1];
              end else begin
                st_q <= ST_WR_BYTE;
                oe_q <= 1'b0;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              st_q  <= ST_WR_BYTE;
              cnt_q <= '0;
              oe_q  <= 1'b0;
            end
          end
          ST_RD_BYTE: begin
            if (scl_fall_i) begin
              if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                st_q <= ST_RD_ACK;
                oe_q <= 1'b0;
              end else begin
                cnt_q <= cnt_q + 1'b1;
                tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                oe_q  <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              acked_q   <= ~sda_i;
              rd_done_o <= 1'b1;
            end else if (scl_fall_i) begin
              if (acked_q) begin
                st_q  <= ST_RD_BYTE;
                cnt_q <= '0;
                tx_q  <= status_i;
                oe_q  <= ~status_i[BYTE_W-1];
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/tsyn_reg_bank.sv
module tsyn_reg_bank
  import tsyn_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wr_stb_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_done_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              cp_o,
  output logic [2:0]        test_o,
  output logic              os_o,
  output logic [BYTE_W-1:0] band_o,
  output logic              por_o
);
  localparam int unsigned HI_W = DIV_W - BYTE_W;

  byte_kind_e        exp_q;
  logic [HI_W-1:0]   hi_stg_q;
  logic [BYTE_W-1:0] lo_stg_q, ctrl_stg_q, band_stg_q;
  logic              hi_v_q, lo_v_q, ctrl_v_q, band_v_q;
  logic              rd_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q      <= EXP_ANY;
      hi_stg_q   <= '0;
      lo_stg_q   <= '0;
      ctrl_stg_q <= '0;
      band_stg_q <= '0;
      hi_v_q     <= 1'b0;
      lo_v_q     <= 1'b0;
      ctrl_v_q   <= 1'b0;
      band_v_q   <= 1'b0;
    end else if (stop_i) begin
      exp_q    <= EXP_ANY;
      hi_v_q   <= 1'b0;
      lo_v_q   <= 1'b0;
      ctrl_v_q <= 1'b0;
      band_v_q <= 1'b0;
    end else if (start_i) begin
      exp_q <= EXP_ANY;
    end else if (wr_stb_i) begin
      unique case (exp_q)
        EXP_DIV_LO: begin
          lo_stg_q <= wr_data_i;
          lo_v_q   <= 1'b1;
          exp_q    <= EXP_ANY;
        end
        EXP_BAND: begin
          band_stg_q <= wr_data_i;
          band_v_q   <= 1'b1;
          exp_q      <= EXP_ANY;
        end
        default: begin
          if (wr_data_i[CTRL_MARK_BIT]) begin
            ctrl_stg_q <= wr_data_i;
            ctrl_v_q   <= 1'b1;
            exp_q      <= EXP_BAND;
          end else begin
            hi_stg_q <= wr_data_i[HI_W-1:0];
            hi_v_q   <= 1'b1;
            lo_v_q   <= 1'b0;
            exp_q    <= EXP_DIV_LO;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o  <= '0;
      cp_o   <= 1'b0;
      test_o <= '0;
      os_o   <= 1'b0;
      band_o <= '0;
    end else if (stop_i) begin
      if (hi_v_q && lo_v_q) div_o <= {hi_stg_q, lo_stg_q};
      if (ctrl_v_q) begin
        cp_o   <= ctrl_stg_q[CTRL_CP_BIT];
        test_o <= ctrl_stg_q[CTRL_T_LSB+:3];
        os_o   <= ctrl_stg_q[CTRL_OS_BIT];
      end
      if (band_v_q) band_o <= band_stg_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_o     <= 1'b1;
      rd_seen_q <= 1'b0;
    end else if (stop_i) begin
      if (rd_seen_q) por_o <= 1'b0;
      rd_seen_q <= 1'b0;
    end else if (rd_done_i) begin
      rd_seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tuner_syn_regs.sv
module tuner_syn_regs
  import tsyn_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_W       = 15,
  parameter int unsigned ADC_W       = 3,
  parameter logic [4:0]  ADDR_HI     = 5'b11000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [1:0]       as_i,
  input  logic             lock_i,
  input  logic [ADC_W-1:0] adc_i,
  output logic [DIV_W-1:0] div_o,
  output logic             cp_o,
  output logic [2:0]       test_o,
  output logic             os_o,
  output logic [7:0]       band_o
);
  localparam int unsigned PAD_W = BYTE_W - 2 - ADC_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb, rd_done, por_flag;
  logic [BYTE_W-1:0] wr_data, status;

  assign status = {por_flag, lock_i, {PAD_W{1'b0}}, adc_i};

  tsyn_line_mon #(.SYNC_STAGES(SYNC_STAGES)) i_line_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  tsyn_bit_engine i_bit_engine (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .sda_i(sda_s),
    .dev_addr_i({ADDR_HI, as_i}), .status_i(status),
    .sda_oe_o, .wr_stb_o(wr_stb), .wr_data_o(wr_data), .rd_done_o(rd_done)
  );

  tsyn_reg_bank #(.DIV_W(DIV_W)) i_reg_bank (
    .clk_i, .rst_ni,
    .start_i(start_det), .stop_i(stop_det),
    .wr_stb_i(wr_stb), .wr_data_i(wr_data), .rd_done_i(rd_done),
    .div_o, .cp_o, .test_o, .os_o, .band_o, .por_o(por_flag)
  );

  logic unused_scl;
  assign unused_scl = scl_s;
endmodule

// File: rtl/tsyn_checker.sv
module tsyn_checker #(
  parameter int unsigned DIV_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_i,
  input logic             sda_oe_i,
  input logic             stop_i,
  input logic             por_i,
  input logic [DIV_W-1:0] div_i,
  input logic             cp_i,
  input logic [2:0]       test_i,
  input logic             os_i,
  input logic [7:0]       band_i
);
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_i) else $error("sda drive changed with scl high"); // R2
  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> $stable(div_i)) else $error("divider moved without stop"); // R5
  AST_CTRL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> $stable({cp_i, test_i, os_i, band_i})) else $error("control moved without stop"); // R5
  AST_POR_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(por_i)) else $error("por flag rose outside reset"); // R8
  AST_POR_FALL_AT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_i) |-> $past(stop_i)) else $error("por cleared away from stop"); // R8
endmodule

bind tuner_syn_regs tsyn_checker #(.DIV_W(DIV_W)) i_tsyn_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_i(sda_oe_o),
  .stop_i(stop_det), .por_i(por_flag), .div_i(div_o), .cp_i(cp_o),
  .test_i(test_o), .os_i(os_o), .band_i(band_o)
);

// File: tb/test_tuner_syn_regs.sv
module test_tuner_syn_regs;
  localparam int QP = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] as_pins = 2'b00;
  logic lock = 1'b1;
  logic [2:0] adc = 3'd5;
  logic sda_oe, cp, os;
  logic [14:0] div;
  logic [2:0] test;
  logic [7:0] band;
  wire sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  tuner_syn_regs i_tuner_syn_regs (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .as_i(as_pins), .lock_i(lock), .adc_i(adc), .div_o(div), .cp_o(cp),
    .test_o(test), .os_o(os), .band_o(band)
  );

  int compared = 0, mismatched = 0, guard = 0, cycles = 0;
  // reference model
  int e_div = 0, e_cp = 0, e_test = 0, e_os = 0, e_band = 0, e_por = 1;
  int kind = 0, p_hi = 0, p_lo = 0, p_ctrl = 0, p_band = 0;
  bit v_hi, v_lo, v_ctrl, v_band, rd_seen, accepted;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    e_div = 0; e_cp = 0; e_test = 0; e_os = 0; e_band = 0; e_por = 1;
    kind = 0; v_hi = 0; v_lo = 0; v_ctrl = 0; v_band = 0; rd_seen = 0; accepted = 0;
  endtask

  task automatic model_byte(input int b);
    if (!accepted) return;
    if (kind == 1) begin p_lo = b; v_lo = 1; kind = 0; end
    else if (kind == 2) begin p_band = b; v_band = 1; kind = 0; end
    else if (b[7]) begin p_ctrl = b; v_ctrl = 1; kind = 2; end
    else begin p_hi = b & 8'h7f; v_hi = 1; v_lo = 0; kind = 1; end
  endtask

  task automatic model_stop();
    if (v_hi && v_lo) e_div = (p_hi << 8) | p_lo;
    if (v_ctrl) begin e_cp = p_ctrl[6]; e_test = (p_ctrl >> 3) & 7; e_os = p_ctrl[0]; end
    if (v_band) e_band = p_band;
    if (rd_seen) e_por = 0;
    v_hi = 0; v_lo = 0; v_ctrl = 0; v_band = 0; rd_seen = 0; kind = 0; accepted = 0;
  endtask

  // per-clock comparison of committed outputs (R5: nothing moves mid-transfer)
  always @(negedge clk) begin
    cycles++;
    if (guard > 0) guard--;
    else if (rst_n) begin
      chk(div == 15'(e_div), "R3/R5 div", div, e_div);
      chk({cp, test, os} == {1'(e_cp), 3'(e_test), 1'(e_os)}, "R4/R5 ctrl",
          {cp, test, os}, {1'(e_cp), 3'(e_test), 1'(e_os)});
      chk(band == 8'(e_band), "R10/R5 band", band, e_band);
    end
  end

  task automatic half(); repeat (QP) @(negedge clk); endtask

  task automatic i2c_start();
    m_sda = 1'b1; half(); m_scl = 1'b1; half();
    m_sda = 1'b0; half(); m_scl = 1'b0; half();
    kind = 0;
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; half(); m_scl = 1'b1; half();
    m_sda = 1'b1; guard = 8; model_stop(); half();
  endtask

  task automatic put_bit(input bit b);
    m_sda = b; half(); m_scl = 1'b1; half(); m_scl = 1'b0;
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; half(); m_scl = 1'b1; repeat (QP / 2) @(negedge clk);
    b = sda_bus; repeat (QP / 2) @(negedge clk); m_scl = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(~give_ack);
    rd_seen = 1;
  endtask

  task automatic write_xfer(input logic [7:0] addr, input logic [7:0] q[$], input bit exp_ack,
                            input string req);
    bit ack;
    i2c_start();
    wr_byte(addr, ack);
    chk(ack == exp_ack, {req, " addr ack"}, ack, exp_ack);
    accepted = exp_ack;
    foreach (q[i]) begin
      wr_byte(q[i], ack);
      if (exp_ack) chk(ack, {req, " data ack"}, ack, 1);
      model_byte(q[i]);
    end
    i2c_stop();
    half();
  endtask

  task automatic read_xfer(input int n, input string req);
    bit ack;
    logic [7:0] v, expv;
    i2c_start();
    wr_byte({5'b11000, as_pins, 1'b1}, ack);
    chk(ack, {req, " read addr ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      expv = {1'(e_por), lock, 3'b000, adc};
      rd_byte(i < n - 1, v);
      chk(v == expv, req, v, expv);
      lock = ~lock; adc = adc + 3'd3;
    end
    i2c_stop();
    half();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; guard = 4; model_reset(); repeat (4) @(negedge clk);
    rst_n = 1'b1; repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cycles > 150000);
    chk(0, "watchdog", cycles, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    do_reset();
    // R1
    chk(div == 0 && cp == 0 && test == 0 && os == 0 && band == 0, "R1 reset outputs",
        {div, cp, test, os, band}, 0);
    chk(sda_oe == 0, "R1 sda released", sda_oe, 0);
    // R7 R8: first read shows por=1, then clears
    read_xfer(1, "R7 status por=1");
    read_xfer(3, "R9 repeated status");  // R8 expects por=0 now
    // R3 divider pair
    q = '{8'h1F, 8'hE2}; write_xfer(8'hC0, q, 1, "R3 divider");
    chk(div == 15'h1FE2, "R3 div value", div, 15'h1FE2);
    // R4 R10 control and band
    q = '{8'hC9, 8'h08}; write_xfer(8'hC0, q, 1, "R4 ctrl");
    chk(cp && test == 3'b001 && os, "R4 ctrl fields", {cp, test, os}, 5'b10011);
    chk(band == 8'h08, "R10 high band", band, 8'h08);
    // R6 lone divider byte
    q = '{8'h05}; write_xfer(8'hC0, q, 1, "R6 lone div");
    chk(div == 15'h1FE2, "R6 div kept", div, 15'h1FE2);
    // R2 wrong address ignored
    q = '{8'h33, 8'h44, 8'h80, 8'h02}; write_xfer(8'hC4, q, 0, "R2 foreign addr");
    chk(div == 15'h1FE2 && band == 8'h08, "R2 no effect", div, 15'h1FE2);
    // R2 select pins move the address
    as_pins = 2'b10;
    q = '{8'h80, 8'h02, 8'h7F, 8'hFF}; write_xfer(8'hC4, q, 1, "R2 pin addr");
    chk(div == 15'h7FFF && band == 8'h02 && !cp && !os, "R2 R10 mid band", {div, band}, {15'h7FFF, 8'h02});
    q = '{8'h12}; write_xfer(8'hC0, q, 0, "R2 old addr");
    // R4 test code and low band, divider and control in one transfer
    q = '{8'hB8, 8'h01, 8'h00, 8'h01}; write_xfer(8'hC4, q, 1, "R4 mixed");
    chk(test == 3'b111 && cp == 0 && band == 8'h01 && div == 15'h0001, "R4 R10 mixed",
        {test, band}, {3'b111, 8'h01});
    // R8 reset restores por
    do_reset();
    as_pins = 2'b00;
    read_xfer(2, "R8 por after reset");
    read_xfer(1, "R8 por stays clear");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule